// File: doc/BRIEF.md
# Masked Tick Compare Timer

This block holds a free-running tick counter and two compare channels. When the counter reaches the programmed value, a channel sends a one-cycle set strobe to the interrupt logic that sits beside it. The first channel, the soft channel, drives the timer bit (bit 16) of the soft interrupt pending register. The second channel, the hypervisor channel, sets the hypervisor interrupt-pending flag to 1. Each compare register is `COUNT_W+1` bits wide. Its top bit disables the channel, and its low `COUNT_W` bits are the value compared against the counter. `COUNT_W` defaults to 63, which puts the disable flag in bit 63.

A write arms its channel for a single match. The channel is armed only when the written value is enabled and greater than the counter value in the write cycle. The thread state comes in as two plain status pins. While the thread is suspended, an armed channel fires at once, so a sleeping thread still wakes. While the thread is halted, the hypervisor channel gives no strobe and drops any match it reaches. Register access uses plain control pins: a write strobe with a channel select, and a combinational read port. The block has no streaming interface and no back-pressure.

Top module: `tick_cmp_timer`

## Requirements
- R1: `count_o` is 0 in the first cycle after reset. It grows by exactly one every clock and wraps modulo 2^COUNT_W.
- R2: After reset, both compare registers read as the disable bit (bit COUNT_W) set with all lower bits 0, and neither strobe is asserted.
- R3: A channel whose register has bit COUNT_W set never strobes. Writing a value with that bit set cancels a pending match on that channel.
- R4: With `wr_sel`=0 the write goes to the soft channel. When armed, it raises `soft_tick_set_o` for exactly one cycle, in the cycle after the one in which `count_o` equals the register's low COUNT_W bits. After firing, the channel is disarmed.
- R5: With `wr_sel`=1 the write goes to the hypervisor channel, which behaves the same way on `hyp_pend_set_o`.
- R6: While `thr_halted` is 1, `hyp_pend_set_o` stays 0. A hypervisor match reached during the halt is consumed without a strobe. The soft channel is unaffected.
- R7: A write whose low COUNT_W bits are less than or equal to `count_o` in the write cycle arms nothing. No strobe follows, even after the counter wraps past that value.
- R8: While `thr_suspended` is 1, an armed and enabled channel fires regardless of the count, with its strobe in the next cycle.
- R9: `rd_data` shows, in the same cycle, the full register chosen by `rd_sel` (0 soft, 1 hypervisor), exactly as last written.
- R10: If a channel is written in the cycle its old value matches, the old match still strobes, and the new value arms according to R7.
- R11: The two channels are independent and may strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 1 | Write target: 0 soft, 1 hypervisor |
| wr_data | input | COUNT_W+1 | Write value; top bit is the disable flag |
| rd_sel | input | 1 | Read select: 0 soft, 1 hypervisor |
| rd_data | output | COUNT_W+1 | Selected compare register |
| thr_halted | input | 1 | Thread halted status |
| thr_suspended | input | 1 | Thread suspended status |
| count_o | output | COUNT_W | Tick counter value |
| soft_tick_set_o | output | 1 | One-cycle set strobe for soft interrupt bit 16 |
| hyp_pend_set_o | output | 1 | One-cycle set strobe for the hypervisor pending flag |

## Verification
Two events can fall in the same cycle: a match firing on a channel, and a register write to that same channel. The bench sets this up by waiting until the counter equals the programmed value and then writing a new, later value in exactly that cycle. The expected result is two pulses: one from the old match and one from the newly armed value. The behavioural model, stepped every clock, judges each pulse against its expected cycle. A second collision, both channels programmed to the same count, must give one cycle in which both strobes are high.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic {
    CH_SOFT = 1'b0,
    CH_HYP  = 1'b1
  } tct_ch_e;
endpackage

// File: rtl/tct_counter.sv
module tct_counter #(
  parameter int W = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + W'(1);
  end
endmodule

// File: rtl/tct_channel.sv
module tct_channel #(
  parameter int W         = 63,
  parameter bit HALT_GATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W:0]   wr_data,
  input  logic [W-1:0] count,
  input  logic         suspended,
  input  logic         halted,
  output logic [W:0]   cmp_o,
  output logic         strobe_o
);
  logic [W:0] cmp_q;
  logic       armed_q;
  logic       hit;
  logic       gate;

  // armed, enabled and either due or woken by suspension
  assign hit  = armed_q & ~cmp_q[W] & ((count == cmp_q[W-1:0]) | suspended);

  generate
    if (HALT_GATE) begin : g_halt
      assign gate = ~halted;
    end else begin : g_free
      assign gate = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q    <= {1'b1, {W{1'b0}}};
      armed_q  <= 1'b0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= hit & gate;
      if (wr_en) begin
        cmp_q   <= wr_data;
        armed_q <= ~wr_data[W] & (wr_data[W-1:0] > count);
      end else if (hit) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign cmp_o = cmp_q;
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tct_pkg::*;
#(
  parameter int COUNT_W = 63,
  localparam int RW = COUNT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [RW-1:0]      wr_data,
  input  logic               rd_sel,
  output logic [RW-1:0]      rd_data,
  input  logic               thr_halted,
  input  logic               thr_suspended,
  output logic [COUNT_W-1:0] count_o,
  output logic               soft_tick_set_o,
  output logic               hyp_pend_set_o
);
  logic [RW-1:0] cmp_w    [NUM_CH];
  logic          strobe_w [NUM_CH];
  logic [RW-1:0] cmp_soft;
  logic [RW-1:0] cmp_hyp;

  tct_counter #(.W(COUNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .count (count_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tct_channel #(
      .W         (COUNT_W),
      .HALT_GATE (i == int'(CH_HYP))
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en && (wr_sel == 1'(i))),
      .wr_data   (wr_data),
      .count     (count_o),
      .suspended (thr_suspended),
      .halted    (thr_halted),
      .cmp_o     (cmp_w[i]),
      .strobe_o  (strobe_w[i])
    );
  end

  assign cmp_soft        = cmp_w[CH_SOFT];
  assign cmp_hyp         = cmp_w[CH_HYP];
  assign rd_data         = rd_sel ? cmp_hyp : cmp_soft;
  assign soft_tick_set_o = strobe_w[CH_SOFT];
  assign hyp_pend_set_o  = strobe_w[CH_HYP];
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int COUNT_W = 63
) (
  input logic               clk,
  input logic               rst_n,
  input logic [COUNT_W-1:0] count_o,
  input logic [COUNT_W:0]   cmp_soft,
  input logic [COUNT_W:0]   cmp_hyp,
  input logic               thr_halted,
  input logic               thr_suspended,
  input logic               soft_tick_set_o,
  input logic               hyp_pend_set_o
);
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count_o == COUNT_W'($past(count_o) + COUNT_W'(1)));

  p_soft_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_tick_set_o |-> !$past(cmp_soft[COUNT_W]));

  p_hyp_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_pend_set_o |-> !$past(cmp_hyp[COUNT_W]));

  p_soft_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    soft_tick_set_o |-> ($past(thr_suspended) ||
                         $past(count_o) == $past(cmp_soft[COUNT_W-1:0])));

  p_hyp_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_pend_set_o |-> ($past(thr_suspended) ||
                        $past(count_o) == $past(cmp_hyp[COUNT_W-1:0])));

  p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_halted |=> !hyp_pend_set_o);
endmodule

bind tick_cmp_timer tct_checker #(.COUNT_W(COUNT_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .count_o         (count_o),
  .cmp_soft        (cmp_soft),
  .cmp_hyp         (cmp_hyp),
  .thr_halted      (thr_halted),
  .thr_suspended   (thr_suspended),
  .soft_tick_set_o (soft_tick_set_o),
  .hyp_pend_set_o  (hyp_pend_set_o)
);

// File: tb/tb_tick_cmp_timer.sv
module tb_tick_cmp_timer;
  localparam int CW = 10;
  localparam int RW = CW + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [RW-1:0] wr_data = '0;
  logic          rd_sel = 1'b0;
  logic [RW-1:0] rd_data;
  logic          thr_halted = 1'b0;
  logic          thr_suspended = 1'b0;
  logic [CW-1:0] count_o;
  logic          soft_tick_set_o;
  logic          hyp_pend_set_o;

  always #4 clk = ~clk;

  tick_cmp_timer #(.COUNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .thr_halted(thr_halted),
    .thr_suspended(thr_suspended), .count_o(count_o),
    .soft_tick_set_o(soft_tick_set_o), .hyp_pend_set_o(hyp_pend_set_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  int pa = 0;
  int pb = 0;
  bit both_seen = 1'b0;

  // behavioural reference model
  logic [CW-1:0] m_cnt;
  logic [RW-1:0] m_cmp [2];
  bit            m_arm [2];
  bit            m_str [2];

  always @(posedge clk) begin
    bit f [2];
    if (!rst_n) begin
      m_cnt <= '0;
      for (int c = 0; c < 2; c++) begin
        m_cmp[c] <= {1'b1, {CW{1'b0}}};
        m_arm[c] <= 1'b0;
        m_str[c] <= 1'b0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        f[c] = m_arm[c] && !m_cmp[c][CW] &&
               ((m_cnt == m_cmp[c][CW-1:0]) || thr_suspended);
        m_str[c] <= f[c] && !(c == 1 && thr_halted);
        if (wr_en && int'(wr_sel) == c) begin
          m_cmp[c] <= wr_data;
          m_arm[c] <= !wr_data[CW] && (wr_data[CW-1:0] > m_cnt);
        end else if (f[c]) begin
          m_arm[c] <= 1'b0;
        end
      end
      m_cnt <= m_cnt + CW'(1);
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      check("R1 count", 64'(count_o), 64'(m_cnt));
      check("R4 soft strobe", 64'(soft_tick_set_o), 64'(m_str[0]));
      check("R5 hyp strobe", 64'(hyp_pend_set_o), 64'(m_str[1]));
      check("R9 read", 64'(rd_data), 64'(m_cmp[rd_sel]));
      pa += int'(soft_tick_set_o);
      pb += int'(hyp_pend_set_o);
      if (soft_tick_set_o && hyp_pend_set_o) both_seen = 1'b1;
      rd_sel <= ~rd_sel;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wr(input bit sel, input bit dis, input int off);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = {dis, CW'(int'(m_cnt) + off)};
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // keep targets clear of the wrap point
  task automatic sync();
    while (int'(m_cnt) > (1 << CW) - 300) @(negedge clk);
    pa = 0;
    pb = 0;
    both_seen = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int t;
    idle(3);
    rst_n = 1'b1;
    // R2: reset values, before the first counting edge
    check("R2 count zero", 64'(count_o), 64'd0);
    check("R2 soft reg", 64'(dut.rd_data), 64'({1'b1, {CW{1'b0}}}));
    rd_sel = 1'b1;
    #1;
    check("R2 hyp reg", 64'(rd_data), 64'({1'b1, {CW{1'b0}}}));
    check("R2 strobes", 64'({soft_tick_set_o, hyp_pend_set_o}), 64'd0);
    cmp_on = 1'b1;
    @(negedge clk);

    // R4 soft channel single shot
    sync(); wr(1'b0, 1'b0, 6); idle(12);
    check("R4 soft pulses", 64'(pa), 64'd1);
    // R5 hypervisor channel
    sync(); wr(1'b1, 1'b0, 4); idle(10);
    check("R5 hyp pulses", 64'(pb), 64'd1);
    // R3 disabled write and cancel of pending
    sync(); wr(1'b0, 1'b1, 3); idle(8);
    check("R3 disabled soft", 64'(pa), 64'd0);
    wr(1'b1, 1'b0, 9); idle(2); wr(1'b1, 1'b1, 6); idle(12);
    check("R3 cancelled hyp", 64'(pb), 64'd0);
    // R7 stale value, observed across a full wrap
    sync(); wr(1'b0, 1'b0, 0); wr(1'b1, 1'b0, -5);
    idle((1 << CW) + 40);
    check("R7 stale soft", 64'(pa), 64'd0);
    check("R7 stale hyp", 64'(pb), 64'd0);
    // R6 halted suppresses hyp, soft unaffected
    sync(); thr_halted = 1'b1;
    wr(1'b1, 1'b0, 3); wr(1'b0, 1'b0, 3); idle(8);
    thr_halted = 1'b0; idle(20);
    check("R6 halted hyp", 64'(pb), 64'd0);
    check("R6 soft during halt", 64'(pa), 64'd1);
    // R8 suspension wakes early
    sync(); wr(1'b0, 1'b0, 200); idle(3);
    thr_suspended = 1'b1; @(negedge clk); thr_suspended = 1'b0;
    idle(2);
    check("R8 early wake", 64'(pa), 64'd1);
    idle(220);
    check("R8 no second", 64'(pa), 64'd1);
    // R11 both channels in one cycle
    sync(); wr(1'b0, 1'b0, 10); wr(1'b1, 1'b0, 9); idle(14);
    check("R11 same cycle", 64'(both_seen), 64'd1);
    // R10 write in the match cycle
    sync(); t = int'(m_cnt) + 4; wr(1'b0, 1'b0, 4);
    while (int'(m_cnt) != t) @(negedge clk);
    wr(1'b0, 1'b0, 5); idle(12);
    check("R10 old and new", 64'(pa), 64'd2);

    idle(4);
    finish_run();
  end
endmodule